// File: doc/BRIEF.md
# Divergent-Branch Lane Mask Controller

This block keeps the per-lane activity mask of one SIMD wave and a last-in, first-out stack of saved (mask, rejoin address) pairs. Structured branches and loops in a wave's instruction stream drive it through a small set of control operations. The operations save the mask, restore it, narrow it by a per-lane condition, and split the wave into a then-path and an else-path. The current mask gates every lane's register write. Whenever a restore moves control flow, the block supplies a next-PC override in the same cycle.

The sequencer presents one operation per cycle on `op_code`, together with the lane condition vector and two addresses. The rejoin address (`join_pc`) is what a save records. The alternate address (`alt_pc`) is the start of the else-path. Each operation takes effect at the next clock edge. The redirect, overflow and underflow indications are combinational and belong to the operation presented in the current cycle. A stack that is too full or empty rejects the operation whole and flags it, so the mask and stack are never left half-updated.

Top module: `emask_top`

## Requirements
- R1: After reset `exec_mask` is all ones and the stack holds no entry, so a restore issued first reports underflow.
- R2: `lane_wr_en` equals `lane_wr_req` AND `exec_mask` in every cycle, lane i on bit i.
- R3: Op code 1 (save) records the current mask with `join_pc` on the stack and leaves the mask unchanged.
- R4: Op code 2 (restore) loads the mask from the top entry and removes the entry. In the same cycle it raises `redirect_valid` with `redirect_pc` equal to the address of that entry. Entries come back in last-in, first-out order.
- R5: Op code 3 (narrow) sets the mask to mask AND `lane_cond` when that result is non-zero, without a redirect.
- R6: When op code 3 yields an all-zero result, it behaves as a restore: it loads the top entry's mask and redirects to that entry's address.
- R7: Op code 4 (split), when both mask AND cond and mask AND NOT cond are non-zero, pushes (current mask, `join_pc`) and then (mask AND NOT cond, `alt_pc`). It sets the mask to mask AND cond, with no redirect.
- R8: Op code 4 with mask AND NOT cond equal to zero pushes only (current mask, `join_pc`) and sets the mask to mask AND cond.
- R9: Op code 4 with mask AND cond equal to zero pushes only (current mask, `join_pc`). It keeps the else lanes as the mask and redirects to `alt_pc` in the same cycle.
- R10: An operation that needs more free entries than remain raises `overflow` and changes neither mask nor stack. A save needs one entry, and a split needs two when both lane sets are non-empty.
- R11: A restore, or an all-zero narrow, on an empty stack raises `underflow`, changes nothing, and gives no redirect.
- R12: Op code 0 and codes 5 to 7 change nothing and raise no output flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | Control operation: 0 none, 1 save, 2 restore, 3 narrow, 4 split |
| lane_cond | input | LANES | Per-lane condition, bit i for lane i |
| join_pc | input | AW | Rejoin address recorded by save and split |
| alt_pc | input | AW | Else-path address used by split |
| lane_wr_req | input | LANES | Per-lane register write requests |
| exec_mask | output | LANES | Current lane activity mask |
| lane_wr_en | output | LANES | Write requests gated by the mask |
| redirect_valid | output | 1 | Next-PC override valid this cycle |
| redirect_pc | output | AW | Next-PC override value |
| overflow | output | 1 | Operation rejected for lack of stack room |
| underflow | output | 1 | Restore rejected on an empty stack |

## Verification
The assertions take for granted that `op_code` and `lane_cond` are known after reset and stay steady through each cycle. They also take for granted that the mask can reach zero only through a narrow, which always falls back to a restore. The stimulus therefore changes inputs only on the falling edge and starts every branch from a non-empty mask. It walks the stack from empty to full and back again, including a split that needs two entries while only one is free.

// File: rtl/emask_pkg.sv
package emask_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_SAVE    = 3'd1,
    OP_RESTORE = 3'd2,
    OP_NARROW  = 3'd3,
    OP_SPLIT   = 3'd4
  } emask_op_e;
endpackage

// File: rtl/emask_lifo.sv
module emask_lifo #(
  parameter int LANES = 8,
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       push_n,
  input  logic             pop,
  input  logic [LANES-1:0] w0_mask,
  input  logic [AW-1:0]    w0_addr,
  input  logic [LANES-1:0] w1_mask,
  input  logic [AW-1:0]    w1_addr,
  output logic [CW-1:0]    count,
  output logic [LANES-1:0] top_mask,
  output logic [AW-1:0]    top_addr
);
  logic [LANES-1:0] m_q [DEPTH];
  logic [AW-1:0]    a_q [DEPTH];
  logic [CW-1:0]    cnt_q, cnt_d, cnt_p1;
  logic [DEPTH-1:0] hit0, hit1;

  assign cnt_p1 = cnt_q + CW'(1);

  // write-slot decode
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit0[i] = (push_n != 2'd0) && (cnt_q  == CW'(i));
      hit1[i] = (push_n == 2'd2) && (cnt_p1 == CW'(i));
    end
  end

  // next occupancy
  always_comb begin
    cnt_d = cnt_q;
    if (pop)                  cnt_d = cnt_q - CW'(1);
    else if (push_n == 2'd1)  cnt_d = cnt_q + CW'(1);
    else if (push_n == 2'd2)  cnt_d = cnt_q + CW'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // storage, datapath only: no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (hit0[i]) begin
        m_q[i] <= w0_mask;
        a_q[i] <= w0_addr;
      end else if (hit1[i]) begin
        m_q[i] <= w1_mask;
        a_q[i] <= w1_addr;
      end
    end
  end

  // top-of-stack read
  always_comb begin
    top_mask = '0;
    top_addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) begin
        top_mask = m_q[i];
        top_addr = a_q[i];
      end
    end
  end

  assign count = cnt_q;

  AST_LIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R10
  AST_LIFO_PUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n == 2'd1) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R3
  AST_LIFO_PUSH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n == 2'd2) |=> (cnt_q == $past(cnt_q) + CW'(2))); // R7
  AST_LIFO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R11
endmodule

// File: rtl/emask_ctrl.sv
module emask_ctrl
  import emask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [2:0]       op_code,
  input  logic [LANES-1:0] cond,
  input  logic [AW-1:0]    join_pc,
  input  logic [AW-1:0]    alt_pc,
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] top_mask,
  input  logic [AW-1:0]    top_addr,
  input  logic [CW-1:0]    count,
  output logic [LANES-1:0] nxt_mask,
  output logic             mask_we,
  output logic [1:0]       push_n,
  output logic             pop,
  output logic [LANES-1:0] w0_mask,
  output logic [AW-1:0]    w0_addr,
  output logic [LANES-1:0] w1_mask,
  output logic [AW-1:0]    w1_addr,
  output logic             redir_vld,
  output logic [AW-1:0]    redir_pc,
  output logic             ovf,
  output logic             udf
);
  localparam logic [CW-1:0] FULL_C  = CW'(DEPTH);
  localparam logic [CW-1:0] ROOM2_C = CW'(DEPTH - 2);

  emask_op_e        op;
  logic [LANES-1:0] then_m, else_m;
  logic             then_any, else_any, empty, full, room2;

  assign op       = emask_op_e'(op_code);
  assign then_m   = cur_mask & cond;
  assign else_m   = cur_mask & ~cond;
  assign then_any = |then_m;
  assign else_any = |else_m;
  assign empty    = (count == '0);
  assign full     = (count == FULL_C);
  assign room2    = (count <= ROOM2_C);

  always_comb begin
    nxt_mask  = cur_mask;
    mask_we   = 1'b0;
    push_n    = 2'd0;
    pop       = 1'b0;
    w0_mask   = cur_mask;
    w0_addr   = join_pc;
    w1_mask   = else_m;
    w1_addr   = alt_pc;
    redir_vld = 1'b0;
    redir_pc  = top_addr;
    ovf       = 1'b0;
    udf       = 1'b0;
    case (op)
      OP_SAVE: begin
        if (full) ovf = 1'b1;
        else      push_n = 2'd1;
      end
      OP_RESTORE: begin
        if (empty) udf = 1'b1;
        else begin
          pop       = 1'b1;
          mask_we   = 1'b1;
          nxt_mask  = top_mask;
          redir_vld = 1'b1;
        end
      end
      OP_NARROW: begin
        if (then_any) begin
          mask_we  = 1'b1;
          nxt_mask = then_m;
        end else if (empty) begin
          udf = 1'b1;
        end else begin
          pop       = 1'b1;
          mask_we   = 1'b1;
          nxt_mask  = top_mask;
          redir_vld = 1'b1;
        end
      end
      OP_SPLIT: begin
        if (then_any && else_any) begin
          if (!room2) ovf = 1'b1;
          else begin
            push_n   = 2'd2;
            mask_we  = 1'b1;
            nxt_mask = then_m;
          end
        end else if (full) begin
          ovf = 1'b1;
        end else if (then_any) begin
          push_n   = 2'd1;
          mask_we  = 1'b1;
          nxt_mask = then_m;
        end else begin
          push_n    = 2'd1;
          mask_we   = 1'b1;
          nxt_mask  = else_m;
          redir_vld = 1'b1;
          redir_pc  = alt_pc;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/emask_lane_gate.sv
module emask_lane_gate #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] req,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] en
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign en[g] = req[g] & mask[g];
  end
endmodule

// File: rtl/emask_top.sv
module emask_top
  import emask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int AW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_code,
  input  logic [LANES-1:0] lane_cond,
  input  logic [AW-1:0]    join_pc,
  input  logic [AW-1:0]    alt_pc,
  input  logic [LANES-1:0] lane_wr_req,
  output logic [LANES-1:0] exec_mask,
  output logic [LANES-1:0] lane_wr_en,
  output logic             redirect_valid,
  output logic [AW-1:0]    redirect_pc,
  output logic             overflow,
  output logic             underflow
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [LANES-1:0] mask_q, mask_d;
  logic             mask_we;
  logic [1:0]       push_n;
  logic             pop;
  logic [LANES-1:0] w0_mask, w1_mask, top_mask;
  logic [AW-1:0]    w0_addr, w1_addr, top_addr;
  logic [CW-1:0]    stack_cnt;

  emask_ctrl #(.LANES(LANES), .AW(AW), .DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .op_code  (op_code),
    .cond     (lane_cond),
    .join_pc  (join_pc),
    .alt_pc   (alt_pc),
    .cur_mask (mask_q),
    .top_mask (top_mask),
    .top_addr (top_addr),
    .count    (stack_cnt),
    .nxt_mask (mask_d),
    .mask_we  (mask_we),
    .push_n   (push_n),
    .pop      (pop),
    .w0_mask  (w0_mask),
    .w0_addr  (w0_addr),
    .w1_mask  (w1_mask),
    .w1_addr  (w1_addr),
    .redir_vld(redirect_valid),
    .redir_pc (redirect_pc),
    .ovf      (overflow),
    .udf      (underflow)
  );

  emask_lifo #(.LANES(LANES), .AW(AW), .DEPTH(DEPTH), .CW(CW)) u_lifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_n  (push_n),
    .pop     (pop),
    .w0_mask (w0_mask),
    .w0_addr (w0_addr),
    .w1_mask (w1_mask),
    .w1_addr (w1_addr),
    .count   (stack_cnt),
    .top_mask(top_mask),
    .top_addr(top_addr)
  );

  emask_lane_gate #(.LANES(LANES)) u_gate (
    .req (lane_wr_req),
    .mask(mask_q),
    .en  (lane_wr_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_d;
  end

  assign exec_mask = mask_q;

  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q != '0); // R6
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> ($stable(mask_q) && $stable(stack_cnt))); // R10
  AST_UDF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (!redirect_valid && !overflow)); // R11
  AST_UDF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> $stable(mask_q)); // R11
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd2 && !underflow) |=> (mask_q == $past(top_mask))); // R4
  AST_SAVE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd1) |=> $stable(mask_q)); // R3
  AST_SPLIT_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd4 && !overflow && (mask_q & lane_cond) == '0)
      |-> (redirect_valid && redirect_pc == alt_pc)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd0 || op_code > 3'd4)
      |-> (!redirect_valid && !overflow && !underflow)); // R12
endmodule

// File: tb/test_emask_top.sv
`timescale 1ns/1ps
module test_emask_top;
  localparam int L = 8;
  localparam int D = 4;
  localparam int A = 16;

  typedef struct {
    string        tag;
    logic         redir;
    logic [A-1:0] pc;
    logic         ovf;
    logic         udf;
    logic [L-1:0] wen;
    logic [L-1:0] mask_after;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   op_code = '0;
  logic [L-1:0] lane_cond = '0;
  logic [A-1:0] join_pc = '0, alt_pc = '0;
  logic [L-1:0] lane_wr_req = '0;
  logic [L-1:0] exec_mask, lane_wr_en;
  logic         redirect_valid, overflow, underflow;
  logic [A-1:0] redirect_pc;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];
  logic [L-1:0] m_mask = '1;
  logic [L-1:0] s_mask[$];
  logic [A-1:0] s_addr[$];

  always #4 clk = ~clk;

  emask_top #(.LANES(L), .DEPTH(D), .AW(A)) i_emask_top (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .lane_cond(lane_cond),
    .join_pc(join_pc), .alt_pc(alt_pc), .lane_wr_req(lane_wr_req),
    .exec_mask(exec_mask), .lane_wr_en(lane_wr_en),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .overflow(overflow), .underflow(underflow)
  );

  // driver: applies one operation and queues what the requirements predict
  task automatic do_op(input logic [2:0] o, input logic [L-1:0] c,
                       input logic [A-1:0] j, input logic [A-1:0] a,
                       input string tag);
    exp_t e;
    logic [L-1:0] thn, els, nm, req;
    int need;
    @(negedge clk);
    req = c ^ 8'h5A;
    op_code = o; lane_cond = c; join_pc = j; alt_pc = a; lane_wr_req = req;
    thn = m_mask & c; els = m_mask & ~c; nm = m_mask;
    e.tag = tag; e.redir = 1'b0; e.pc = '0; e.ovf = 1'b0; e.udf = 1'b0;
    e.wen = req & m_mask;
    case (o)
      3'd1: if (s_mask.size() == D) e.ovf = 1'b1;
            else begin s_mask.push_back(m_mask); s_addr.push_back(j); end
      3'd2, 3'd3: begin
        if (o == 3'd3 && thn != '0) nm = thn;
        else if (s_mask.size() == 0) e.udf = 1'b1;
        else begin
          nm = s_mask.pop_back(); e.pc = s_addr.pop_back(); e.redir = 1'b1;
        end
      end
      3'd4: begin
        need = (thn != '0 && els != '0) ? 2 : 1;
        if (s_mask.size() + need > D) e.ovf = 1'b1;
        else begin
          s_mask.push_back(m_mask); s_addr.push_back(j);
          if (thn != '0) begin
            if (els != '0) begin s_mask.push_back(els); s_addr.push_back(a); end
            nm = thn;
          end else begin
            nm = els; e.redir = 1'b1; e.pc = a;
          end
        end
      end
      default: ;
    endcase
    m_mask = nm;
    e.mask_after = nm;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    op_code = '0; lane_cond = '0; lane_wr_req = '0;
  endtask

  // monitor: compares same-cycle outputs, then the mask after the edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (redirect_valid !== e.redir || (e.redir && redirect_pc !== e.pc) ||
            overflow !== e.ovf || underflow !== e.udf) begin
          failures++;
          $display("FAIL %s flags: redir=%b pc=%h ovf=%b udf=%b expected redir=%b pc=%h ovf=%b udf=%b",
                   e.tag, redirect_valid, redirect_pc, overflow, underflow,
                   e.redir, e.pc, e.ovf, e.udf);
        end
        checks++;
        if (lane_wr_en !== e.wen) begin
          failures++;
          $display("FAIL R2 lane_wr_en=%h expected %h", lane_wr_en, e.wen);
        end
        @(posedge clk);
        #1;
        checks++;
        if (exec_mask !== e.mask_after) begin
          failures++;
          $display("FAIL %s exec_mask=%h expected %h", e.tag, exec_mask, e.mask_after);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (exec_mask !== 8'hFF) begin
      failures++;
      $display("FAIL R1 reset exec_mask=%h expected ff", exec_mask);
    end
    // R1 / R11: empty stack after reset
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R1");
    // R12: unused code and none
    do_op(3'd7, 8'h33, 16'h0001, 16'h0002, "R12");
    do_op(3'd0, 8'h0F, 16'h0001, 16'h0002, "R12");
    // R3, R5, R4: odd-lane condition and restore
    do_op(3'd1, 8'h00, 16'h0010, 16'h0000, "R3");
    do_op(3'd3, 8'hAA, 16'h0000, 16'h0000, "R5");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R4");
    // R7: two-way split, then both entries back in order
    do_op(3'd4, 8'h0F, 16'h0040, 16'h0030, "R7");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R7");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R7");
    // R8: all lanes take the then-path, one entry only
    do_op(3'd4, 8'hFF, 16'h0044, 16'h0033, "R8");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R8");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R8");
    // R9: no lane takes the then-path
    do_op(3'd1, 8'h00, 16'h0050, 16'h0000, "R9");
    do_op(3'd3, 8'h3C, 16'h0000, 16'h0000, "R9");
    do_op(3'd4, 8'hC3, 16'h0070, 16'h0060, "R9");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R9");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R9");
    // R6: narrow to nothing pops
    do_op(3'd1, 8'h00, 16'h0080, 16'h0000, "R6");
    do_op(3'd3, 8'h0F, 16'h0000, 16'h0000, "R5");
    do_op(3'd3, 8'hF0, 16'h0000, 16'h0000, "R6");
    // R10: fill to depth, then overflow
    do_op(3'd1, 8'h00, 16'h0101, 16'h0000, "R10");
    do_op(3'd3, 8'h7F, 16'h0000, 16'h0000, "R10");
    do_op(3'd1, 8'h00, 16'h0102, 16'h0000, "R10");
    do_op(3'd3, 8'h3F, 16'h0000, 16'h0000, "R10");
    do_op(3'd1, 8'h00, 16'h0103, 16'h0000, "R10");
    do_op(3'd3, 8'h1F, 16'h0000, 16'h0000, "R10");
    do_op(3'd1, 8'h00, 16'h0104, 16'h0000, "R10");
    do_op(3'd1, 8'h00, 16'h0105, 16'h0000, "R10");
    do_op(3'd4, 8'h01, 16'h0106, 16'h0107, "R10");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R4");
    // one slot free: two-entry split rejected, one-entry split accepted
    do_op(3'd4, 8'h0F, 16'h0108, 16'h0109, "R10");
    do_op(3'd4, 8'hFF, 16'h010A, 16'h010B, "R8");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R4");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R4");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R4");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R4");
    // R11: empty-stack restore and zero narrow
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R11");
    do_op(3'd3, 8'h00, 16'h0000, 16'h0000, "R11");
    do_op(3'd4, 8'h81, 16'h0200, 16'h0201, "R7");
    do_op(3'd3, 8'h80, 16'h0000, 16'h0000, "R5");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R7");
    do_op(3'd2, 8'h00, 16'h0000, 16'h0000, "R7");
    idle();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule